// File: doc/BRIEF.md
# Store Buffer With Load Forwarding

This block holds stores that have left address generation but have not yet been written to the data cache. Each slot records one store and moves through four states: empty, address held while the data is still pending, address and data held but not yet retired, and retired and waiting to drain. A store claims a slot when its address arrives, and it may bring its data in the same cycle. Data can also come later through a separate write port that names the slot. Retirement commits stores one at a time, oldest first. The oldest retired store is then presented on a valid/ready cache write port. Once that port accepts it, the slot is freed.

Every cycle, a load address and a byte mask are checked against all occupied slots. Every buffered store counts as older than the load. The load gets one of three answers. It may go to the cache (bypass). It may take its bytes from a buffered store (forward). It may be cancelled so that it issues again later (abort). The answer depends only on the youngest store that overlaps the load. A strict build option gives the simplest policy instead: a load may proceed only when the buffer is empty.

Top module: `store_fwd_buffer`

## Requirements
- R1: After reset every slot is empty. `sa_ready` is 1, `sa_slot` is 0, `cw_valid` is 0, and any lookup returns bypass (code 0) with zero data.
- R2: When `sa_valid` and `sa_ready` are both high, the store takes the slot reported on `sa_slot`. Slots are taken in circular order. With `sa_dvalid` high the slot holds data at once; otherwise it waits for data.
- R3: With DEPTH slots occupied, `sa_ready` is low. A store address offered while `sa_ready` is low has no effect.
- R4: A data write to a slot that is waiting for data stores the data, and the slot then forwards it. A data write to a slot in any other state is ignored.
- R5: `cm_valid` commits the oldest uncommitted store if its data is present. If that store still lacks data, or no uncommitted store exists, the commit is ignored.
- R6: `cw_valid` is high exactly when the oldest slot is committed. `cw_addr`, `cw_be` and `cw_data` then show that store and stay stable until `cw_ready`. On acceptance the slot frees, so at most one store drains per cycle, in program order.
- R7: A load that overlaps no occupied slot (same word address and at least one shared byte) returns bypass (code 0) and zero data.
- R8: If the deciding slot is still waiting for data, the load returns abort (code 2).
- R9: If the deciding slot holds data, whether committed or not, and its byte mask covers every byte the load asks for, the load returns forward (code 1). The data is the store's data with the bytes the load did not ask for cleared.
- R10: If the deciding slot holds data but lacks some byte the load asks for, the load returns abort (code 2).
- R11: When several slots overlap the load, the most recently allocated one decides the result, whatever the older ones hold.
- R12: With EMPTY_ONLY set, a load returns abort when any slot is occupied and bypass otherwise, whatever its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sa_valid | input | 1 | Store address offered |
| sa_ready | output | 1 | A free slot exists |
| sa_addr | input | ADDR_W | Store word address |
| sa_be | input | DATA_W/8 | Store byte mask |
| sa_dvalid | input | 1 | Store data arrives with the address |
| sa_data | input | DATA_W | Store data when `sa_dvalid` is high |
| sa_slot | output | $clog2(DEPTH) | Slot the next accepted store takes |
| sd_valid | input | 1 | Late store data write |
| sd_slot | input | $clog2(DEPTH) | Slot the late data belongs to |
| sd_data | input | DATA_W | Late store data |
| cm_valid | input | 1 | Retirement commits the oldest uncommitted store |
| ld_addr | input | ADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Load byte mask |
| ld_res | output | 2 | 0 bypass, 1 forward, 2 abort |
| ld_data | output | DATA_W | Forwarded data, masked by `ld_be` |
| cw_valid | output | 1 | Committed store ready for the cache |
| cw_ready | input | 1 | Cache accepts the presented store |
| cw_addr | output | ADDR_W | Draining store word address |
| cw_be | output | DATA_W/8 | Draining store byte mask |
| cw_data | output | DATA_W | Draining store data |

## Verification
Some properties are checked on every cycle. The occupancy never exceeds DEPTH, and the committed count never exceeds the occupancy. The cache write port holds its payload while stalled. Each accepted store or drain changes the occupancy by exactly one. No reserved result code appears, and in the strict variant an occupied buffer always aborts.

Other behaviour shows only through the bench's scenarios. These are the choice of the youngest overlapping slot, the forward/abort split on partial byte coverage, and the data masking. They also include ignored data writes and commits, the rejection of a store offered while full, and drain order against a reference model driven by random traffic.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   // Slot lifecycle; the lookup and drain logic decode these values.
   typedef enum logic [1:0] {
      ST_FREE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_READY = 2'd2,
      ST_DONE  = 2'd3
   } slot_state_t;

   // Load lookup answer as seen on the ld_res port.
   typedef enum logic [1:0] {
      LK_BYPASS  = 2'd0,
      LK_FORWARD = 2'd1,
      LK_ABORT   = 2'd2
   } lookup_res_t;

endpackage

// File: rtl/sbuf_slot.sv
module sbuf_slot
   import sbuf_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int DATA_W = 32,
   parameter int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              alloc_i,
   input  logic              alloc_full_i,
   input  logic [ADDR_W-1:0] alloc_addr_i,
   input  logic [BE_W-1:0]   alloc_be_i,
   input  logic [DATA_W-1:0] alloc_data_i,
   input  logic              dwr_i,
   input  logic [DATA_W-1:0] dwr_data_i,
   input  logic              cmt_i,
   input  logic              free_i,
   output logic [1:0]        state_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BE_W-1:0]   be_o,
   output logic [DATA_W-1:0] data_o
);

   slot_state_t       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] data_q;

   // The controller never raises two strobes for one slot in a cycle.
   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_FREE;
         addr_q  <= '0;
         be_q    <= '0;
         data_q  <= '0;
      end else if (alloc_i) begin
         state_q <= alloc_full_i ? ST_READY : ST_ADDR;
         addr_q  <= alloc_addr_i;
         be_q    <= alloc_be_i;
         if (alloc_full_i) begin
            data_q <= alloc_data_i;
         end
      end else if (free_i) begin
         state_q <= ST_FREE;
      end else if (cmt_i) begin
         state_q <= ST_DONE;
      end else if (dwr_i && state_q == ST_ADDR) begin
         state_q <= ST_READY;
         data_q  <= dwr_data_i;
      end
   end

   assign state_o = state_q;
   assign addr_o  = addr_q;
   assign be_o    = be_q;
   assign data_o  = data_q;

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
   import sbuf_pkg::*;
#(
   parameter  int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sa_valid_i,
   input  logic                  sd_valid_i,
   input  logic [IDX_W-1:0]      sd_slot_i,
   input  logic                  cm_valid_i,
   input  logic                  cw_ready_i,
   input  logic [DEPTH-1:0][1:0] state_i,
   output logic                  sa_ready_o,
   output logic                  drain_valid_o,
   output logic [DEPTH-1:0]      alloc_o,
   output logic [DEPTH-1:0]      dwr_o,
   output logic [DEPTH-1:0]      cmt_o,
   output logic [DEPTH-1:0]      free_o,
   output logic [IDX_W-1:0]      head_o,
   output logic [IDX_W-1:0]      tail_o,
   output logic [CNT_W-1:0]      used_o,
   output logic [CNT_W-1:0]      cmt_cnt_o
);

   logic [IDX_W-1:0] head_q;
   logic [CNT_W-1:0] used_q;
   logic [CNT_W-1:0] ncmt_q;
   logic [IDX_W-1:0] tail;
   logic [IDX_W-1:0] cptr;
   logic             sa_fire;
   logic             drain_fire;
   logic             cmt_fire;
   logic             dwr_fire;

   // Power-of-two depth lets the pointers wrap by plain overflow.
   assign tail = head_q + used_q[IDX_W-1:0];
   assign cptr = head_q + ncmt_q[IDX_W-1:0];

   assign sa_ready_o    = (used_q != CNT_W'(DEPTH));
   assign sa_fire       = sa_valid_i && sa_ready_o;
   assign drain_valid_o = (used_q != '0) && (state_i[head_q] == ST_DONE);
   assign drain_fire    = drain_valid_o && cw_ready_i;
   assign cmt_fire      = cm_valid_i && (ncmt_q != used_q) && (state_i[cptr] == ST_READY);
   assign dwr_fire      = sd_valid_i && (state_i[sd_slot_i] == ST_ADDR);

   for (genvar i = 0; i < DEPTH; i++) begin : g_strobe
      assign alloc_o[i] = sa_fire    && (tail      == IDX_W'(i));
      assign dwr_o[i]   = dwr_fire   && (sd_slot_i == IDX_W'(i));
      assign cmt_o[i]   = cmt_fire   && (cptr      == IDX_W'(i));
      assign free_o[i]  = drain_fire && (head_q    == IDX_W'(i));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q <= '0;
         used_q <= '0;
         ncmt_q <= '0;
      end else begin
         head_q <= head_q + IDX_W'(drain_fire);
         used_q <= used_q + CNT_W'(sa_fire) - CNT_W'(drain_fire);
         ncmt_q <= ncmt_q + CNT_W'(cmt_fire) - CNT_W'(drain_fire);
      end
   end

   assign head_o    = head_q;
   assign tail_o    = tail;
   assign used_o    = used_q;
   assign cmt_cnt_o = ncmt_q;

endmodule

// File: rtl/sbuf_lookup.sv
module sbuf_lookup
   import sbuf_pkg::*;
#(
   parameter  int DEPTH      = 4,
   parameter  int ADDR_W     = 30,
   parameter  int DATA_W     = 32,
   parameter  int BE_W       = DATA_W / 8,
   parameter  bit EMPTY_ONLY = 1'b0,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic [IDX_W-1:0]             head_i,
   input  logic [CNT_W-1:0]             used_i,
   input  logic [DEPTH-1:0][1:0]        state_i,
   input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
   input  logic [DEPTH-1:0][BE_W-1:0]   be_i,
   input  logic [DEPTH-1:0][DATA_W-1:0] data_i,
   input  logic [ADDR_W-1:0]            ld_addr_i,
   input  logic [BE_W-1:0]              ld_be_i,
   output lookup_res_t                  res_o,
   output logic [DATA_W-1:0]            data_o
);

   logic [DATA_W-1:0] byte_mask;

   for (genvar b = 0; b < BE_W; b++) begin : g_mask
      assign byte_mask[b*8 +: 8] = {8{ld_be_i[b]}};
   end

   if (EMPTY_ONLY) begin : g_strict
      // Strict policy: any buffered store holds every load back.
      assign res_o  = (used_i != '0) ? LK_ABORT : LK_BYPASS;
      assign data_o = '0;
   end else begin : g_match
      logic             hit;
      logic [IDX_W-1:0] hit_idx;
      logic [IDX_W-1:0] pos;

      // Walk oldest to youngest; a later overlap overrides an earlier one.
      always_comb begin
         hit     = 1'b0;
         hit_idx = '0;
         pos     = '0;
         for (int k = 0; k < DEPTH; k++) begin
            pos = head_i + IDX_W'(k);
            if ((CNT_W'(k) < used_i) && (state_i[pos] != ST_FREE) &&
                (addr_i[pos] == ld_addr_i) && ((be_i[pos] & ld_be_i) != '0)) begin
               hit     = 1'b1;
               hit_idx = pos;
            end
         end
      end

      always_comb begin
         res_o  = LK_BYPASS;
         data_o = '0;
         if (hit) begin
            if (state_i[hit_idx] == ST_ADDR) begin
               res_o = LK_ABORT;
            end else if ((ld_be_i & ~be_i[hit_idx]) != '0) begin
               res_o = LK_ABORT;
            end else begin
               res_o  = LK_FORWARD;
               data_o = data_i[hit_idx] & byte_mask;
            end
         end
      end
   end

endmodule

// File: rtl/store_fwd_buffer.sv
module store_fwd_buffer
   import sbuf_pkg::*;
#(
   parameter  int DEPTH      = 4,
   parameter  int ADDR_W     = 30,
   parameter  int DATA_W     = 32,
   parameter  bit EMPTY_ONLY = 1'b0,
   localparam int BE_W       = DATA_W / 8,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sa_valid,
   output logic              sa_ready,
   input  logic [ADDR_W-1:0] sa_addr,
   input  logic [BE_W-1:0]   sa_be,
   input  logic              sa_dvalid,
   input  logic [DATA_W-1:0] sa_data,
   output logic [IDX_W-1:0]  sa_slot,
   input  logic              sd_valid,
   input  logic [IDX_W-1:0]  sd_slot,
   input  logic [DATA_W-1:0] sd_data,
   input  logic              cm_valid,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [BE_W-1:0]   ld_be,
   output logic [1:0]        ld_res,
   output logic [DATA_W-1:0] ld_data,
   output logic              cw_valid,
   input  logic              cw_ready,
   output logic [ADDR_W-1:0] cw_addr,
   output logic [BE_W-1:0]   cw_be,
   output logic [DATA_W-1:0] cw_data
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("store_fwd_buffer: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("store_fwd_buffer: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("store_fwd_buffer: ADDR_W must be at least 1");
   end

   logic [DEPTH-1:0][1:0]        st_vec;
   logic [DEPTH-1:0][ADDR_W-1:0] addr_vec;
   logic [DEPTH-1:0][BE_W-1:0]   be_vec;
   logic [DEPTH-1:0][DATA_W-1:0] data_vec;
   logic [DEPTH-1:0]             alloc_v;
   logic [DEPTH-1:0]             dwr_v;
   logic [DEPTH-1:0]             cmt_v;
   logic [DEPTH-1:0]             free_v;
   logic [IDX_W-1:0]             head_w;
   logic [IDX_W-1:0]             tail_w;
   logic [CNT_W-1:0]             used_w;
   logic [CNT_W-1:0]             cmt_w;
   lookup_res_t                  lk_res;

   sbuf_ctrl #(.DEPTH(DEPTH)) i_ctrl (
      .clk           (clk),
      .rst           (rst),
      .sa_valid_i    (sa_valid),
      .sd_valid_i    (sd_valid),
      .sd_slot_i     (sd_slot),
      .cm_valid_i    (cm_valid),
      .cw_ready_i    (cw_ready),
      .state_i       (st_vec),
      .sa_ready_o    (sa_ready),
      .drain_valid_o (cw_valid),
      .alloc_o       (alloc_v),
      .dwr_o         (dwr_v),
      .cmt_o         (cmt_v),
      .free_o        (free_v),
      .head_o        (head_w),
      .tail_o        (tail_w),
      .used_o        (used_w),
      .cmt_cnt_o     (cmt_w)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      sbuf_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) i_slot (
         .clk          (clk),
         .rst          (rst),
         .alloc_i      (alloc_v[i]),
         .alloc_full_i (sa_dvalid),
         .alloc_addr_i (sa_addr),
         .alloc_be_i   (sa_be),
         .alloc_data_i (sa_data),
         .dwr_i        (dwr_v[i]),
         .dwr_data_i   (sd_data),
         .cmt_i        (cmt_v[i]),
         .free_i       (free_v[i]),
         .state_o      (st_vec[i]),
         .addr_o       (addr_vec[i]),
         .be_o         (be_vec[i]),
         .data_o       (data_vec[i])
      );
   end

   sbuf_lookup #(
      .DEPTH      (DEPTH),
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .BE_W       (BE_W),
      .EMPTY_ONLY (EMPTY_ONLY)
   ) i_lookup (
      .head_i    (head_w),
      .used_i    (used_w),
      .state_i   (st_vec),
      .addr_i    (addr_vec),
      .be_i      (be_vec),
      .data_i    (data_vec),
      .ld_addr_i (ld_addr),
      .ld_be_i   (ld_be),
      .res_o     (lk_res),
      .data_o    (ld_data)
   );

   assign ld_res  = lk_res;
   assign sa_slot = tail_w;
   assign cw_addr = addr_vec[head_w];
   assign cw_be   = be_vec[head_w];
   assign cw_data = data_vec[head_w];

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
   parameter  int DEPTH      = 4,
   parameter  int ADDR_W     = 30,
   parameter  int DATA_W     = 32,
   parameter  bit EMPTY_ONLY = 1'b0,
   localparam int BE_W       = DATA_W / 8,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              sa_valid,
   input logic              sa_ready,
   input logic              cw_valid,
   input logic              cw_ready,
   input logic [ADDR_W-1:0] cw_addr,
   input logic [BE_W-1:0]   cw_be,
   input logic [DATA_W-1:0] cw_data,
   input logic [1:0]        ld_res,
   input logic [CNT_W-1:0]  used,
   input logic [CNT_W-1:0]  cmt_cnt
);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      used <= CNT_W'(DEPTH));

   p_cmt_within_used_r5: assert property (@(posedge clk) disable iff (rst)
      cmt_cnt <= used);

   p_drain_needs_commit_r6: assert property (@(posedge clk) disable iff (rst)
      cw_valid |-> cmt_cnt != '0);

   p_drain_hold_r6: assert property (@(posedge clk) disable iff (rst)
      cw_valid && !cw_ready |=> cw_valid && $stable(cw_addr) && $stable(cw_be) && $stable(cw_data));

   p_drain_shrinks_r6: assert property (@(posedge clk) disable iff (rst)
      cw_valid && cw_ready && !(sa_valid && sa_ready) |=> used == $past(used) - CNT_W'(1));

   p_alloc_grows_r2: assert property (@(posedge clk) disable iff (rst)
      sa_valid && sa_ready && !(cw_valid && cw_ready) |=> used == $past(used) + CNT_W'(1));

   p_res_code_r9: assert property (@(posedge clk) disable iff (rst)
      ld_res != 2'd3);

   if (EMPTY_ONLY) begin : g_strict_chk
      p_strict_abort_r12: assert property (@(posedge clk) disable iff (rst)
         used != '0 |-> ld_res == 2'd2);
   end

endmodule

bind store_fwd_buffer sbuf_checker #(
   .DEPTH      (DEPTH),
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .EMPTY_ONLY (EMPTY_ONLY)
) i_checker (
   .clk      (clk),
   .rst      (rst),
   .sa_valid (sa_valid),
   .sa_ready (sa_ready),
   .cw_valid (cw_valid),
   .cw_ready (cw_ready),
   .cw_addr  (cw_addr),
   .cw_be    (cw_be),
   .cw_data  (cw_data),
   .ld_res   (ld_res),
   .used     (used_w),
   .cmt_cnt  (cmt_w)
);

// File: tb/test_store_fwd_buffer.sv
module test_store_fwd_buffer;

   localparam int D = 4;

   logic        clk = 1'b0;
   logic        rst;
   logic        sa_valid, sa_dvalid, sd_valid, cm_valid, cw_ready;
   logic [29:0] sa_addr, ld_addr;
   logic [3:0]  sa_be, ld_be;
   logic [31:0] sa_data, sd_data;
   logic [1:0]  sd_slot;

   logic        sa_ready, cw_valid;
   logic [1:0]  sa_slot, ld_res;
   logic [31:0] ld_data, cw_data;
   logic [29:0] cw_addr;
   logic [3:0]  cw_be;

   logic        s_sa_ready, s_cw_valid;
   logic [1:0]  s_sa_slot, s_ld_res;
   logic [31:0] s_ld_data, s_cw_data;
   logic [29:0] s_cw_addr;
   logic [3:0]  s_cw_be;

   int n_chk = 0;
   int n_bad = 0;

   // reference model
   int          m_st[D];
   logic [29:0] m_addr[D];
   logic [3:0]  m_be[D];
   logic [31:0] m_data[D];
   int          m_head, m_cnt, m_ncmt;

   always #2.5 clk = ~clk;

   store_fwd_buffer #(.DEPTH(D), .ADDR_W(30), .DATA_W(32), .EMPTY_ONLY(1'b0)) i_store_fwd_buffer (
      .clk(clk), .rst(rst), .sa_valid(sa_valid), .sa_ready(sa_ready), .sa_addr(sa_addr),
      .sa_be(sa_be), .sa_dvalid(sa_dvalid), .sa_data(sa_data), .sa_slot(sa_slot),
      .sd_valid(sd_valid), .sd_slot(sd_slot), .sd_data(sd_data), .cm_valid(cm_valid),
      .ld_addr(ld_addr), .ld_be(ld_be), .ld_res(ld_res), .ld_data(ld_data),
      .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_be(cw_be), .cw_data(cw_data)
   );

   store_fwd_buffer #(.DEPTH(D), .ADDR_W(30), .DATA_W(32), .EMPTY_ONLY(1'b1)) i_store_fwd_buffer_strict (
      .clk(clk), .rst(rst), .sa_valid(sa_valid), .sa_ready(s_sa_ready), .sa_addr(sa_addr),
      .sa_be(sa_be), .sa_dvalid(sa_dvalid), .sa_data(sa_data), .sa_slot(s_sa_slot),
      .sd_valid(sd_valid), .sd_slot(sd_slot), .sd_data(sd_data), .cm_valid(cm_valid),
      .ld_addr(ld_addr), .ld_be(ld_be), .ld_res(s_ld_res), .ld_data(s_ld_data),
      .cw_valid(s_cw_valid), .cw_ready(cw_ready), .cw_addr(s_cw_addr), .cw_be(s_cw_be), .cw_data(s_cw_data)
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic set_idle();
      sa_valid = 0; sa_addr = '0; sa_be = 4'hF; sa_dvalid = 0; sa_data = '0;
      sd_valid = 0; sd_slot = '0; sd_data = '0; cm_valid = 0; cw_ready = 0;
      ld_addr = 30'h3FFF_FFFF; ld_be = 4'hF;
   endtask

   task automatic model_reset();
      for (int i = 0; i < D; i++) begin
         m_st[i] = 0; m_addr[i] = '0; m_be[i] = '0; m_data[i] = '0;
      end
      m_head = 0; m_cnt = 0; m_ncmt = 0;
   endtask

   // expected lookup from the requirements: youngest overlapping slot decides
   task automatic mlook(input logic [29:0] a, input logic [3:0] be,
                        output int res, output logic [31:0] d, output string tag);
      int hit = -1;
      int nmatch = 0;
      for (int k = 0; k < m_cnt; k++) begin
         int i = (m_head + k) % D;
         if (m_st[i] != 0 && m_addr[i] == a && (m_be[i] & be) != 0) begin
            hit = i; nmatch++;
         end
      end
      d = '0;
      if (hit < 0) begin
         res = 0; tag = "R7";
      end else if (m_st[hit] == 1) begin
         res = 2; tag = "R8";
      end else if ((be & ~m_be[hit]) != 0) begin
         res = 2; tag = "R10";
      end else begin
         res = 1; tag = "R9";
         for (int b = 0; b < 4; b++) if (be[b]) d[b*8 +: 8] = m_data[hit][b*8 +: 8];
      end
      if (nmatch > 1) tag = "R11";
   endtask

   task automatic model_step(input bit cwv);
      int  tl = (m_head + m_cnt) % D;
      int  cp = (m_head + m_ncmt) % D;
      bit  df = cwv && cw_ready;
      bit  af = sa_valid && (m_cnt < D);
      bit  cf = cm_valid && (m_ncmt < m_cnt) && (m_st[cp] == 2);
      bit  wf = sd_valid && (m_st[sd_slot] == 1);
      if (wf) begin m_st[sd_slot] = 2; m_data[sd_slot] = sd_data; end
      if (cf) m_st[cp] = 3;
      if (af) begin
         m_st[tl] = sa_dvalid ? 2 : 1; m_addr[tl] = sa_addr; m_be[tl] = sa_be;
         if (sa_dvalid) m_data[tl] = sa_data;
      end
      if (df) m_st[m_head] = 0;
      m_head = (m_head + int'(df)) % D;
      m_cnt  = m_cnt + int'(af) - int'(df);
      m_ncmt = m_ncmt + int'(cf) - int'(df);
   endtask

   // compare all outputs against the model, then advance one clock
   task automatic tick();
      int          r;
      logic [31:0] d;
      string       t;
      bit          cwv;
      #1;
      chk("R3", "sa_ready", sa_ready, m_cnt < D);
      if (m_cnt < D) chk("R2", "sa_slot", sa_slot, (m_head + m_cnt) % D);
      cwv = (m_cnt > 0) && (m_st[m_head] == 3);
      chk("R6", "cw_valid", cw_valid, cwv);
      if (cwv) begin
         chk("R6", "cw_addr", cw_addr, m_addr[m_head]);
         chk("R6", "cw_be", cw_be, m_be[m_head]);
         chk("R6", "cw_data", cw_data, m_data[m_head]);
      end
      mlook(ld_addr, ld_be, r, d, t);
      chk(t, "ld_res", ld_res, r);
      chk(t, "ld_data", ld_data, d);
      chk("R12", "strict ld_res", s_ld_res, (m_cnt != 0) ? 2 : 0);
      @(posedge clk);
      model_step(cwv);
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1;
      set_idle();
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 0;
   endtask

   function automatic logic [3:0] pick_be();
      case ($urandom % 6)
         0: return 4'hF;
         1: return 4'h3;
         2: return 4'hC;
         3: return 4'h1;
         4: return 4'h6;
         default: return 4'(($urandom % 15) + 1);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h51B0_0F0D));
      do_reset();

      // R1: state right after reset
      ld_addr = 30'h10;
      #1;
      chk("R1", "sa_ready", sa_ready, 1);
      chk("R1", "sa_slot", sa_slot, 0);
      chk("R1", "cw_valid", cw_valid, 0);
      chk("R1", "ld_res", ld_res, 0);
      chk("R1", "ld_data", ld_data, 0);
      chk("R12", "strict empty", s_ld_res, 0);
      tick();

      // slot0: address only
      set_idle(); sa_valid = 1; sa_addr = 30'h10; sa_be = 4'hF; tick();
      set_idle(); ld_addr = 30'h10; #1; chk("R8", "addr only abort", ld_res, 2); tick();
      // R4: late data fills slot0
      set_idle(); sd_valid = 1; sd_slot = 0; sd_data = 32'h1122_3344; tick();
      set_idle(); ld_addr = 30'h10; #1;
      chk("R4", "filled res", ld_res, 1);
      chk("R4", "filled data", ld_data, 32'h1122_3344);
      sd_valid = 1; sd_slot = 0; sd_data = 32'hDEAD_BEEF; tick();
      set_idle(); ld_addr = 30'h10; #1; chk("R4", "second write ignored", ld_data, 32'h1122_3344); tick();
      // R11: younger address-only store overrides older ready one
      set_idle(); sa_valid = 1; sa_addr = 30'h10; sa_be = 4'hF; tick();
      set_idle(); ld_addr = 30'h10; #1; chk("R11", "younger pending wins", ld_res, 2); tick();
      set_idle(); sa_valid = 1; sa_addr = 30'h10; sa_be = 4'h3; sa_dvalid = 1; sa_data = 32'hAABB_CCDD; tick();
      set_idle(); ld_addr = 30'h10; ld_be = 4'h3; #1;
      chk("R11", "youngest ready wins", ld_res, 1);
      chk("R11", "youngest data", ld_data, 32'h0000_CCDD);
      tick();
      set_idle(); ld_addr = 30'h10; ld_be = 4'hF; #1; chk("R10", "partial cover abort", ld_res, 2); tick();
      // R5 / R6: commit and drain
      set_idle(); cm_valid = 1; tick();
      set_idle(); cm_valid = 1; #1;
      chk("R6", "committed drains", cw_valid, 1);
      chk("R6", "drain data", cw_data, 32'h1122_3344);
      tick();
      set_idle(); cw_ready = 1; tick();
      set_idle(); sd_valid = 1; sd_slot = 1; sd_data = 32'h5566_7788; #1;
      chk("R5", "commit of pending store ignored", cw_valid, 0);
      tick();
      set_idle(); #1; chk("R5", "ready but uncommitted", cw_valid, 0); tick();
      set_idle(); cm_valid = 1; tick();
      set_idle(); #1;
      chk("R5", "commit after data", cw_valid, 1);
      chk("R5", "commit data", cw_data, 32'h5566_7788);
      tick();

      // R3: fill and offer one more
      do_reset();
      for (int i = 0; i < D; i++) begin
         set_idle(); sa_valid = 1; sa_addr = 30'(32 + i); sa_dvalid = 1; sa_data = 32'(i); tick();
      end
      set_idle(); #1; chk("R3", "full ready low", sa_ready, 0);
      sa_valid = 1; sa_addr = 30'h3F; sa_dvalid = 1; sa_data = 32'h99; tick();
      set_idle(); ld_addr = 30'h3F; #1; chk("R3", "store while full ignored", ld_res, 0); tick();

      // random traffic
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         sa_valid  = ($urandom % 100) < 35;
         sa_addr   = 30'($urandom % 4);
         sa_be     = pick_be();
         sa_dvalid = $urandom % 2;
         sa_data   = $urandom;
         sd_valid  = ($urandom % 100) < 40;
         sd_slot   = 2'($urandom % 4);
         sd_data   = $urandom;
         cm_valid  = ($urandom % 100) < 45;
         cw_ready  = ($urandom % 100) < 60;
         ld_addr   = 30'($urandom % 6);
         ld_be     = pick_be();
         tick();
      end

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule